// File: doc/BRIEF.md
# Host-Stepped NAND Flash Cycle Engine

This block lets a host processor run an 8-bit NAND flash device one bus cycle at a time through a small register window. The host first writes a control word into the mode register. That word holds the chip-enable, command-latch, address-latch, write-enable, ECC and channel bits. The host then touches the data register. Each data access takes the staged control word onto the flash pins and, where the word calls for it, runs one write or read strobe with fixed timing. While the strobe runs, the register handshake is held off.

A page program goes as follows:
- A command byte is written with command latch set.
- Three or four address bytes are written with address latch set.
- 512 data bytes are written with ECC folding on.
- The six ECC bytes are read back through the data register and written as spare data, together with the rest of the spare area. ECC folding is off during this phase.
- The program command is issued, and the busy flag in the status register is polled until it clears.
- Writing zero to the mode register, then making a dummy data access, releases the device.

The ECC is two 3-byte Hamming codes, one for each 256-byte half of the page. Each code carries line parity over the byte index and column parity over the bit position.

Top module: `nand_host_if`

## Requirements
- R1: After reset, every chip-enable output is high, write and read strobes are high, command and address latch outputs are low, the data output enable is low and `reg_ready` is high.
- R2: A mode-register write (`reg_addr`=0) does not change any flash pin. The staged control word reaches the pins on the next data-register access (`reg_addr`=1). A data write whose word has chip enable clear, or has none of command latch, address latch and write enable set, updates the pins without any strobe.
- R3: Mode bit 0 is chip enable and bit 1 is command latch. A data write with both set produces one write strobe with `nf_cle` high and the written byte on `nf_dq_out`.
- R4: Mode bit 2 is address latch. A data write with chip enable and address latch set produces one write strobe with `nf_ale` high and the byte on `nf_dq_out`.
- R5: Each write strobe holds `nf_we_n` low for STROBE_LOW clocks (2) and then high for STROBE_HIGH clocks (2). `nf_dq_out` is stable across the rising edge, and `reg_ready` stays low until the strobe cycle is over.
- R6: With chip enable set and ECC read-out (bit 6) clear, a data read pulses `nf_re_n` low for STROBE_LOW clocks and returns the `nf_dq_in` value in `reg_rdata`. The write and read strobes are never low together.
- R7: A mode write with bit 5 set clears both ECC codes and the byte counter, and resets the read-out pointer to 0.
- R8: Mode bit 3 is write enable and bit 4 is ECC enable. With chip enable, write enable and ECC enable set, and both latch bits clear, each data write folds its byte into the ECC. Bytes 0–255 go to code 0 and bytes 256–511 go to code 1. Bytes after the 512th, and bytes written with ECC enable clear, are not folded.
- R9: In each code:
  - Byte 0 holds line-parity pairs {odd,even} for index bits 0–3, with the even term in the lower bit.
  - Byte 1 holds the same pairs for index bits 4–7.
  - Byte 2 holds, from bit 2 upward, pairs {set,clear} for bit-position bits 0–2, with bits 1:0 equal to 1.
  With read-out selected, successive data reads return code 0 bytes 0..2 and then code 1 bytes 0..2, and the pointer wraps after six reads.
- R10: Status register (`reg_addr`=2) bit 0 reads 1 while `nf_rb_n` is low, after passing through a two-flop synchronizer.
- R11: Mode bit 7 selects the channel. Only `nf_ce_n[chan]` is driven low while chip enable is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 mode, 1 data, 2 status |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while ready after a read |
| reg_ready | output | 1 | High when a request can be accepted |
| nf_ce_n | output | NCH | Per-channel chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Data toward the flash |
| nf_dq_oe | output | 1 | Output enable for the data bus |
| nf_dq_in | input | 8 | Data from the flash |
| nf_rb_n | input | 1 | Ready/busy from the flash, low while busy |

## Verification
The assertions assume the following about the host side:
- The host issues at most one of write or read per cycle.
- The host places a request only while `reg_ready` is high, so no access lands inside a running strobe.
- `reg_addr` is one of the three defined selects.

The bench's host tasks wait for ready at a falling edge, then hold a single request for exactly one clock. The flash-side inputs `nf_dq_in` and `nf_rb_n` are changed only between accesses, so the synchronizer and read capture always see settled values.

// File: rtl/nand_if_pkg.sv
// Shared types for the NAND cycle engine.
// Assumes an 8-bit data path and a one-bit channel field.
package nand_if_pkg;

    // Mode register layout, bit 7 down to bit 0
    typedef struct packed {
        logic chan;
        logic ecc_rd;
        logic ecc_clr;
        logic ecc_en;
        logic we;
        logic ale;
        logic cle;
        logic ce;
    } mode_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOW  = 2'd1,
        SEQ_HIGH = 2'd2
    } seq_state_t;

    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

endpackage

// File: rtl/nand_strobe_seq.sv
// Strobe sequencer: runs one write or read strobe per start pulse.
// The strobe is low for LOW_CLKS clocks, then high for HIGH_CLKS clocks.
// Assumes that start is only raised while idle is high.
module nand_strobe_seq
    import nand_if_pkg::*;
#(
    parameter int LOW_CLKS  = 2,
    parameter int HIGH_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd,
    output logic we_n,
    output logic re_n,
    output logic sample,
    output logic idle
);
    localparam int MAXC = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CLKS - 1);
    localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CLKS - 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          op_rd;

    // Phase counter: steps IDLE -> LOW -> HIGH -> IDLE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            op_rd <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state <= SEQ_LOW;
                    cnt   <= '0;
                    op_rd <= rd;
                end
                SEQ_LOW: if (cnt == LOW_LAST) begin
                    state <= SEQ_HIGH;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SEQ_HIGH: if (cnt == HIGH_LAST) begin
                    state <= SEQ_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign we_n   = !(state == SEQ_LOW && !op_rd);
    assign re_n   = !(state == SEQ_LOW && op_rd);
    assign sample = (state == SEQ_LOW) && (cnt == LOW_LAST) && op_rd;
    assign idle   = (state == SEQ_IDLE);

endmodule

// File: rtl/nand_ecc_gen.sv
// Page ECC generator with one Hamming code per half page.
// Each code has line parity over the byte index and column parity over the bit position.
// Assumes PAGE_BYTES = 512, so each half has an 8-bit index and packs into 3 bytes.
module nand_ecc_gen #(
    parameter int PAGE_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       fold,
    input  logic [7:0] din,
    input  logic [2:0] rd_sel,
    output logic [7:0] rd_byte
);
    localparam int HALF = PAGE_BYTES / 2;
    localparam int IW   = $clog2(HALF);
    localparam int CNTW = $clog2(PAGE_BYTES) + 1;

    logic [CNTW-1:0] cnt;
    logic            full;
    logic [2:0]      col1, col0;
    logic            bpar;
    logic [23:0]     code [2];

    assign full = cnt[CNTW-1];
    assign bpar = ^din;

    // Byte counter: saturates once a full page has been folded
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (fold && !full) cnt <= cnt + 1'b1;
    end

    // Column parity of the incoming byte, grouped by bit-position bits
    always_comb begin
        col1 = '0;
        col0 = '0;
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 8; j++) begin
                if (((j >> k) & 1) == 1) col1[k] = col1[k] ^ din[j];
                else                     col0[k] = col0[k] ^ din[j];
            end
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [IW-1:0] lp1, lp0;
        logic [2:0]    cp1, cp0;
        logic [15:0]   lpi;
        logic          hit;

        assign hit = fold && !clr && !full && (cnt[IW] == 1'(h));

        // Accumulate line and column parity for this half
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lp1 <= '0;
                lp0 <= '0;
                cp1 <= '0;
                cp0 <= '0;
            end else if (hit) begin
                for (int b = 0; b < IW; b++) begin
                    if (cnt[b]) lp1[b] <= lp1[b] ^ bpar;
                    else        lp0[b] <= lp0[b] ^ bpar;
                end
                cp1 <= cp1 ^ col1;
                cp0 <= cp0 ^ col0;
            end
        end

        // Interleave line-parity pairs: even term in the lower bit
        always_comb begin
            for (int b = 0; b < 8; b++) begin
                lpi[2*b]     = lp0[b];
                lpi[2*b + 1] = lp1[b];
            end
        end

        assign code[h] = {cp1[2], cp0[2], cp1[1], cp0[1], cp1[0], cp0[0], 2'b11, lpi};
    end

    // Read-out select: code 0 bytes 0..2, then code 1 bytes 0..2
    always_comb begin
        case (rd_sel)
            3'd0:    rd_byte = code[0][7:0];
            3'd1:    rd_byte = code[0][15:8];
            3'd2:    rd_byte = code[0][23:16];
            3'd3:    rd_byte = code[1][7:0];
            3'd4:    rd_byte = code[1][15:8];
            3'd5:    rd_byte = code[1][23:16];
            default: rd_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/nand_busy_sync.sv
// Synchronizer for the ready/busy line. Reports busy when the line is low.
// Assumes that the line is asynchronous to clk. Resets to "not busy".
module nand_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n,
    output logic busy
);
    logic [STAGES-1:0] sync_q;

    // Shift the raw line through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], rb_n};
    end

    assign busy = !sync_q[STAGES-1];

endmodule

// File: rtl/nand_host_if.sv
// Host-stepped NAND cycle engine (top).
// The host stages a control word in the mode register. Each data-register access
// applies that word to the pins and, if the word calls for it, runs one strobe.
// Assumes one request per cycle, issued only while reg_ready is high, and NCH <= 2.
module nand_host_if
    import nand_if_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int STROBE_LOW  = 2,
    parameter int STROBE_HIGH = 2,
    parameter int PAGE_BYTES  = 512
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     reg_addr,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    output logic           reg_ready,
    output logic [NCH-1:0] nf_ce_n,
    output logic           nf_cle,
    output logic           nf_ale,
    output logic           nf_we_n,
    output logic           nf_re_n,
    output logic [7:0]     nf_dq_out,
    output logic           nf_dq_oe,
    input  logic [7:0]     nf_dq_in,
    input  logic           nf_rb_n
);
    localparam int ECC_BYTES = 6;

    mode_t      shadow, mode_nxt;
    logic       pin_ce, pin_cle, pin_ale, pin_chan;
    logic       wr_acc, rd_acc, data_wr, data_rd;
    logic       strobe_wr, strobe_rd, ecc_read, fold, ecc_clr;
    logic       seq_sample, seq_idle, busy;
    logic [2:0] ecc_ptr;
    logic [7:0] ecc_byte;

    assign mode_nxt  = mode_t'(reg_wdata);
    assign wr_acc    = reg_ready && reg_wr;
    assign rd_acc    = reg_ready && reg_rd && !reg_wr;
    assign data_wr   = wr_acc && (reg_addr == SEL_DATA);
    assign data_rd   = rd_acc && (reg_addr == SEL_DATA);
    assign strobe_wr = data_wr && shadow.ce && !shadow.ecc_rd
                       && (shadow.cle || shadow.ale || shadow.we);
    assign ecc_read  = data_rd && shadow.ecc_rd;
    assign strobe_rd = data_rd && !shadow.ecc_rd && shadow.ce;
    assign fold      = data_wr && shadow.ce && shadow.we && shadow.ecc_en
                       && !shadow.cle && !shadow.ale && !shadow.ecc_rd;
    assign ecc_clr   = wr_acc && (reg_addr == SEL_MODE) && mode_nxt.ecc_clr;
    assign reg_ready = seq_idle;

    nand_strobe_seq #(.LOW_CLKS(STROBE_LOW), .HIGH_CLKS(STROBE_HIGH)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (strobe_wr || strobe_rd),
        .rd     (strobe_rd),
        .we_n   (nf_we_n),
        .re_n   (nf_re_n),
        .sample (seq_sample),
        .idle   (seq_idle)
    );

    nand_ecc_gen #(.PAGE_BYTES(PAGE_BYTES)) u_ecc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ecc_clr),
        .fold    (fold),
        .din     (reg_wdata),
        .rd_sel  (ecc_ptr),
        .rd_byte (ecc_byte)
    );

    nand_busy_sync #(.STAGES(2)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .rb_n  (nf_rb_n),
        .busy  (busy)
    );

    // Mode register: stage the control word
    always_ff @(posedge clk) begin
        if (!rst_n) shadow <= '0;
        else if (wr_acc && reg_addr == SEL_MODE) shadow <= mode_nxt;
    end

    // Pin latch: the staged word reaches the pins on a data access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_ce   <= 1'b0;
            pin_cle  <= 1'b0;
            pin_ale  <= 1'b0;
            pin_chan <= 1'b0;
        end else if (data_wr || data_rd) begin
            pin_ce   <= shadow.ce;
            pin_cle  <= shadow.cle;
            pin_ale  <= shadow.ale;
            pin_chan <= shadow.chan;
        end
    end

    // Output data bus: load on a write, release on a strobed read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nf_dq_out <= '0;
            nf_dq_oe  <= 1'b0;
        end else if (strobe_wr) begin
            nf_dq_out <= reg_wdata;
            nf_dq_oe  <= 1'b1;
        end else if (strobe_rd) begin
            nf_dq_oe  <= 1'b0;
        end
    end

    // ECC read-out pointer: clears with the ECC, wraps after six bytes
    always_ff @(posedge clk) begin
        if (!rst_n || ecc_clr) ecc_ptr <= '0;
        else if (ecc_read) ecc_ptr <= (ecc_ptr == 3'(ECC_BYTES - 1)) ? '0 : ecc_ptr + 1'b1;
    end

    // Read data: select by register and access kind
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else if (seq_sample) reg_rdata <= nf_dq_in;
        else if (rd_acc && reg_addr == SEL_MODE) reg_rdata <= shadow;
        else if (rd_acc && reg_addr == SEL_STAT) reg_rdata <= {7'b0, busy};
        else if (ecc_read) reg_rdata <= ecc_byte;
        else if (data_rd && !strobe_rd) reg_rdata <= 8'h00;
    end

    assign nf_cle = pin_cle;
    assign nf_ale = pin_ale;

    for (genvar c = 0; c < NCH; c++) begin : g_ce
        assign nf_ce_n[c] = !(pin_ce && (pin_chan == 1'(c)));
    end

endmodule

// File: rtl/nand_host_if_chk.sv
// Protocol checker for nand_host_if, attached to it with bind.
// Assumes that host requests arrive only while reg_ready is high.
module nand_host_if_chk #(
    parameter int NCH        = 2,
    parameter int STROBE_LOW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     reg_addr,
    input logic           reg_wr,
    input logic           reg_ready,
    input logic [NCH-1:0] nf_ce_n,
    input logic           nf_cle,
    input logic           nf_ale,
    input logic           nf_we_n,
    input logic           nf_re_n,
    input logic [7:0]     nf_dq_out
);
    logic [7:0] low_cnt;

    // Count the cycles that the write strobe has been low
    always_ff @(posedge clk) begin
        if (!rst_n || nf_we_n) low_cnt <= '0;
        else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 1'b1;
    end

    a_r5_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_we_n) |-> (low_cnt == 8'(STROBE_LOW)));

    a_r5_dq_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_we_n) |-> $stable(nf_dq_out));

    a_r5_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !reg_ready);

    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    a_r11_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nf_ce_n));

    a_r2_mode_no_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ready && reg_wr && reg_addr == 2'd0)
        |=> ($stable(nf_cle) && $stable(nf_ale) && $stable(nf_ce_n)));

endmodule

bind nand_host_if nand_host_if_chk #(.NCH(NCH), .STROBE_LOW(STROBE_LOW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_ready (reg_ready),
    .nf_ce_n   (nf_ce_n),
    .nf_cle    (nf_cle),
    .nf_ale    (nf_ale),
    .nf_we_n   (nf_we_n),
    .nf_re_n   (nf_re_n),
    .nf_dq_out (nf_dq_out)
);

// File: tb/nand_host_if_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the host tasks queue the expected flash write cycles,
// and a monitor compares them at each rising edge of the write strobe.
module nand_host_if_test;
    localparam int NCH = 2;
    localparam logic [7:0] M_CE = 8'h01, M_CLE = 8'h02, M_ALE = 8'h04, M_WE = 8'h08,
                           M_EEN = 8'h10, M_ECLR = 8'h20, M_ERD = 8'h40, M_CH = 8'h80;

    logic           clk = 1'b0, rst_n = 1'b0;
    logic [1:0]     reg_addr = '0;
    logic           reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]     reg_wdata = '0, reg_rdata;
    logic           reg_ready;
    logic [NCH-1:0] nf_ce_n;
    logic           nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]     nf_dq_out;
    logic [7:0]     nf_dq_in = 8'h00;
    logic           nf_rb_n = 1'b1;

    int errors = 0, checks = 0;
    logic [7:0] cur_mode = 8'h00;
    logic       ready_after;
    logic [7:0] page [512];
    logic [7:0] exp_ecc [6];
    int         re_width = 0;

    typedef struct packed { logic cle; logic ale; logic [1:0] ce_n; logic [7:0] d; } cyc_t;
    cyc_t exp_q[$];

    nand_host_if #(.NCH(NCH)) uut (.*);

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_access(input logic [1:0] a, input logic wr, input logic [7:0] d);
        @(negedge clk);
        while (!reg_ready) @(negedge clk);
        reg_addr = a; reg_wr = wr; reg_rd = !wr; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        ready_after = reg_ready;
        while (!reg_ready) @(negedge clk);
    endtask

    task automatic set_mode(input logic [7:0] m);
        cur_mode = m;
        host_access(2'd0, 1'b1, m);
    endtask

    task automatic flash_write(input logic [7:0] d);
        cyc_t e;
        e.cle = cur_mode[1]; e.ale = cur_mode[2];
        e.ce_n = cur_mode[7] ? 2'b01 : 2'b10; e.d = d;
        exp_q.push_back(e);
        host_access(2'd1, 1'b1, d);
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        host_access(a, 1'b0, 8'h00);
        d = reg_rdata;
    endtask

    // ECC model written from the requirement text
    task automatic build_ecc();
        for (int h = 0; h < 2; h++) begin
            logic [7:0] l1, l0; logic [2:0] c1, c0;
            l1 = 0; l0 = 0; c1 = 0; c0 = 0;
            for (int i = 0; i < 256; i++) begin
                logic [7:0] v; v = page[h*256 + i];
                for (int b = 0; b < 8; b++)
                    if (i[b]) l1[b] ^= ^v; else l0[b] ^= ^v;
                for (int k = 0; k < 3; k++)
                    for (int j = 0; j < 8; j++)
                        if (j[k]) c1[k] ^= v[j]; else c0[k] ^= v[j];
            end
            for (int b = 0; b < 4; b++) begin
                exp_ecc[h*3][2*b] = l0[b];     exp_ecc[h*3][2*b+1] = l1[b];
                exp_ecc[h*3+1][2*b] = l0[b+4]; exp_ecc[h*3+1][2*b+1] = l1[b+4];
            end
            exp_ecc[h*3+2] = {c1[2], c0[2], c1[1], c0[1], c1[0], c0[0], 2'b11};
        end
    endtask

    // Monitor: compare each finished write strobe with the queue head
    logic prev_we = 1'b1, prev_re = 1'b1;
    int   we_low = 0, re_low = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nf_we_n) we_low++;
            else if (!prev_we) begin
                if (exp_q.size() == 0) check("R3 unexpected strobe", 32'(nf_dq_out), 32'hFFFF);
                else begin
                    cyc_t e; e = exp_q.pop_front();
                    check("R5 low width", 32'(we_low), 32'd2);
                    check("R3/R4 data", 32'(nf_dq_out), 32'(e.d));
                    check("R3 cle", 32'(nf_cle), 32'(e.cle));
                    check("R4 ale", 32'(nf_ale), 32'(e.ale));
                    check("R11 ce", 32'(nf_ce_n), 32'(e.ce_n));
                end
                we_low = 0;
            end
            if (!nf_re_n) re_low++;
            else if (!prev_re) begin re_width = re_low; re_low = 0; end
            prev_we = nf_we_n; prev_re = nf_re_n;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ce_n", 32'(nf_ce_n), 32'h3);
        check("R1 strobes", {nf_we_n, nf_re_n}, 2'b11);
        check("R1 latches/oe", {nf_cle, nf_ale, nf_dq_oe}, 3'b000);
        check("R1 ready", 32'(reg_ready), 32'd1);

        // R2 mode write does not reach pins
        set_mode(M_CE | M_CLE);
        check("R2 pins held", {nf_ce_n, nf_cle}, 3'b110);

        // R3 command cycle; R5 ready held during strobe
        flash_write(8'h80);
        check("R5 ready low in strobe", 32'(ready_after), 32'd0);

        // R4 address cycles
        set_mode(M_CE | M_ALE);
        flash_write(8'h12); flash_write(8'h34); flash_write(8'h05);

        // R7/R8 data phase with ECC
        set_mode(M_ECLR | M_CE);
        set_mode(M_CE | M_WE | M_EEN);
        for (int i = 0; i < 512; i++) begin
            page[i] = 8'((i * 37 + (i >> 3) * 11 + 5) & 255);
            flash_write(page[i]);
        end
        for (int i = 0; i < 4; i++) flash_write(8'hA0 + 8'(i)); // R8 beyond page
        build_ecc();

        // R9 read-out
        set_mode(M_CE | M_ERD);
        for (int k = 0; k < 6; k++) begin
            host_read(2'd1, d);
            check("R9 ecc byte", 32'(d), 32'(exp_ecc[k]));
        end

        // R8 spare bytes are not folded
        set_mode(M_CE | M_WE);
        for (int i = 0; i < 16; i++) flash_write(8'(i * 9 + 1));
        set_mode(M_CE | M_ERD);
        for (int k = 0; k < 6; k++) begin
            host_read(2'd1, d);
            check("R8 ecc unchanged", 32'(d), 32'(exp_ecc[k]));
        end

        // R7 clear
        set_mode(M_CE | M_ERD | M_ECLR);
        for (int k = 0; k < 6; k++) begin
            host_read(2'd1, d);
            check("R7 cleared ecc", 32'(d), (k % 3 == 2) ? 32'h03 : 32'h00);
        end

        // program command
        set_mode(M_CE | M_CLE);
        flash_write(8'h10);

        // R10 busy flag
        nf_rb_n = 1'b0;
        repeat (3) @(negedge clk);
        host_read(2'd2, d);
        check("R10 busy", 32'(d), 32'h01);
        nf_rb_n = 1'b1;
        repeat (3) @(negedge clk);
        host_read(2'd2, d);
        check("R10 ready", 32'(d), 32'h00);

        // R6 read cycle
        set_mode(M_CE);
        nf_dq_in = 8'hA5;
        host_read(2'd1, d);
        check("R6 read data", 32'(d), 32'hA5);
        check("R6 re width", 32'(re_width), 32'd2);

        // R11 channel select via dummy write (R2 no strobe)
        set_mode(M_CE | M_CH);
        host_access(2'd1, 1'b1, 8'h00);
        check("R2 dummy no wait", 32'(ready_after), 32'd1);
        check("R11 ce channel 1", 32'(nf_ce_n), 32'h1);

        // R2 release
        set_mode(8'h00);
        check("R2 ce held before access", 32'(nf_ce_n), 32'h1);
        host_access(2'd1, 1'b1, 8'h00);
        check("R2 ce released", 32'(nf_ce_n), 32'h3);

        repeat (4) @(negedge clk);
        check("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule